// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins a host-side open-drain data line to a card-side open-drain data line and decides, transfer by transfer, which side is talking. Each line pair has its own lane. A lane idles in a neutral state with neither side pulled. The first side seen low becomes the input. After a programmable propagation delay, the lane pulls the opposite side low to copy the level across. When the input side goes high again, the lane keeps the copy for a shorter release delay and then lets go, which returns the pair to neutral.

A reception enable from the session sequencer gates every lane. While the enable is low, each lane holds its card line low and leaves its host line released. Once the enable rises, the lanes move to neutral. All delays are counted in clock cycles. The default counts model 100 ns for the falling edge and 25 ns for the rising edge at a 200 MHz clock, which leaves ample margin for a 1 MHz data rate. The analog pull-ups and the level shifting sit outside the block.

Top module: `line_dir_arbiter`

## Requirements
- R1: While rst_n is low, every lane drives card_pull high and host_pull low.
- R2: While rx_en is low, every lane drives card_pull=1 and host_pull=0 from the next clock edge on, whatever direction it held before. Line levels are ignored while rx_en is low.
- R3: One edge after rx_en is seen high in the forced state, the lane is neutral, with card_pull=0 and host_pull=0.
- R4: A neutral lane that samples host_lvl=0 and card_lvl=1 raises card_pull exactly FALL_CYC edges later, and host_pull stays 0.
- R5: A neutral lane that samples card_lvl=0 and host_lvl=1 raises host_pull exactly FALL_CYC edges later, and card_pull stays 0.
- R6: If a neutral lane samples both levels low on the same edge, the host side becomes the input when HOST_WINS_TIE=1 (the default), so card_pull rises after FALL_CYC edges.
- R7: When the input line is sampled high while its copy is driven, the copy stays driven for RISE_CYC edges and is then released. The lane is then neutral.
- R8: While a direction is pending or held, the level of the output-side line has no effect on either pull.
- R9: If the input line returns high before FALL_CYC edges have elapsed, the lane returns to neutral without ever driving the output side.
- R10: Lanes are independent: activity on one pair never changes the pulls of another.
- R11: Once released, a lane arbitrates afresh. If the former output line is still held low by its far side, that side becomes the new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Reception enable from the session sequencer |
| host_lvl | input | LANES | Sampled level of each host-side line |
| card_lvl | input | LANES | Sampled level of each card-side line |
| host_pull | output | LANES | Pull-down enable for each host-side line |
| card_pull | output | LANES | Pull-down enable for each card-side line |

## Verification
Two events can land on the same sample edge. The first is a fall on both lines of a neutral pair, where the tie rule must settle the direction. The second is a release finishing while the far side still holds the former output line low, so that re-arbitration follows on the very next edge. The bench sets up both cases directly. A tie is made by pulling both sides of a neutral pair on one edge. The second case is made by keeping the card side low while the host side lets go. A further edge collision comes from dropping rx_en mid-transfer. A cycle-accurate reference model in the bench, fed with random pulls on all three pairs, judges every cycle.

// File: rtl/lda_pkg.sv
package lda_pkg;

   typedef enum logic [2:0] {
      LANE_HOLD      = 3'd0,
      LANE_IDLE      = 3'd1,
      LANE_H_WAIT    = 3'd2,
      LANE_H_DRIVE   = 3'd3,
      LANE_H_RELEASE = 3'd4,
      LANE_C_WAIT    = 3'd5,
      LANE_C_DRIVE   = 3'd6,
      LANE_C_RELEASE = 3'd7
   } lane_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_count);
      return (max_count > 1) ? $clog2(max_count) : 1;
   endfunction

endpackage

// File: rtl/lda_timer.sv
module lda_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [CW-1:0] limit,
   output logic          hit
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (cnt_q == limit);

endmodule

// File: rtl/lda_lane.sv
module lda_lane
   import lda_pkg::*;
#(
   parameter int unsigned FALL_CYC      = 20,
   parameter int unsigned RISE_CYC      = 5,
   parameter bit          HOST_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic host_lvl,
   input  logic card_lvl,
   output logic host_pull,
   output logic card_pull
);

   localparam int unsigned MAXD = (FALL_CYC > RISE_CYC) ? FALL_CYC : RISE_CYC;
   localparam int unsigned CW   = cnt_width(MAXD);
   localparam logic [CW-1:0] FALL_LIM = CW'(FALL_CYC - 1);
   localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);

   lane_state_e state_q, state_d;
   logic        tmr_hit, tmr_clr, timed;
   logic [CW-1:0] tmr_lim;
   logic        host_claims, card_claims;

   generate
      if (HOST_WINS_TIE) begin : g_tie_host
         assign host_claims = !host_lvl;
         assign card_claims = !card_lvl && host_lvl;
      end else begin : g_tie_card
         assign host_claims = !host_lvl && card_lvl;
         assign card_claims = !card_lvl;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (!rx_en) begin
         state_d = LANE_HOLD;
      end else begin
         unique case (state_q)
            LANE_HOLD:      state_d = LANE_IDLE;
            LANE_IDLE: begin
               if (host_claims)      state_d = LANE_H_WAIT;
               else if (card_claims) state_d = LANE_C_WAIT;
            end
            LANE_H_WAIT: begin
               if (host_lvl)     state_d = LANE_IDLE;
               else if (tmr_hit) state_d = LANE_H_DRIVE;
            end
            LANE_H_DRIVE:   if (host_lvl) state_d = LANE_H_RELEASE;
            LANE_H_RELEASE: if (tmr_hit)  state_d = LANE_IDLE;
            LANE_C_WAIT: begin
               if (card_lvl)     state_d = LANE_IDLE;
               else if (tmr_hit) state_d = LANE_C_DRIVE;
            end
            LANE_C_DRIVE:   if (card_lvl) state_d = LANE_C_RELEASE;
            LANE_C_RELEASE: if (tmr_hit)  state_d = LANE_IDLE;
            default:        state_d = LANE_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LANE_HOLD;
      else        state_q <= state_d;
   end

   assign timed   = (state_q == LANE_H_WAIT) || (state_q == LANE_C_WAIT) ||
                    (state_q == LANE_H_RELEASE) || (state_q == LANE_C_RELEASE);
   assign tmr_clr = !timed || (state_d != state_q);
   assign tmr_lim = ((state_q == LANE_H_WAIT) || (state_q == LANE_C_WAIT)) ? FALL_LIM : RISE_LIM;

   lda_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clr),
      .limit (tmr_lim),
      .hit   (tmr_hit)
   );

   assign card_pull = (state_q == LANE_HOLD) || (state_q == LANE_H_DRIVE) ||
                      (state_q == LANE_H_RELEASE);
   assign host_pull = (state_q == LANE_C_DRIVE) || (state_q == LANE_C_RELEASE);

   // R2
   hold_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (card_pull && !host_pull));

   // R3
   idle_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_en) && card_pull) |=> (!card_pull && !host_pull));

   // R5
   host_copy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_pull) |-> !$past(card_lvl));

   // R4
   card_copy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_pull) |-> (!$past(host_lvl) || !$past(rx_en)));

   // R8
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_pull && card_pull));

endmodule

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter
   import lda_pkg::*;
#(
   parameter int unsigned LANES         = 3,
   parameter int unsigned FALL_CYC      = 20,
   parameter int unsigned RISE_CYC      = 5,
   parameter bit          HOST_WINS_TIE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [LANES-1:0] host_lvl,
   input  logic [LANES-1:0] card_lvl,
   output logic [LANES-1:0] host_pull,
   output logic [LANES-1:0] card_pull
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("line_dir_arbiter: LANES must be at least 1");
      end
      if (FALL_CYC < 1) begin : g_bad_fall
         $error("line_dir_arbiter: FALL_CYC must be at least 1");
      end
      if (RISE_CYC < 1) begin : g_bad_rise
         $error("line_dir_arbiter: RISE_CYC must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         lda_lane #(
            .FALL_CYC      (FALL_CYC),
            .RISE_CYC      (RISE_CYC),
            .HOST_WINS_TIE (HOST_WINS_TIE)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_en     (rx_en),
            .host_lvl  (host_lvl[i]),
            .card_lvl  (card_lvl[i]),
            .host_pull (host_pull[i]),
            .card_pull (card_pull[i])
         );
      end
   endgenerate

endmodule

// File: tb/line_dir_arbiter_test.sv
`timescale 1ns/1ps
module line_dir_arbiter_test;

   localparam int N = 3;
   localparam int F = 20;
   localparam int R = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0;
   logic [N-1:0] host_ext = '0, card_ext = '0;
   logic [N-1:0] host_lvl, card_lvl, host_pull, card_pull;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   assign host_lvl = ~(host_ext | host_pull);
   assign card_lvl = ~(card_ext | card_pull);

   line_dir_arbiter #(.LANES(N), .FALL_CYC(F), .RISE_CYC(R)) uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
      .host_lvl(host_lvl), .card_lvl(card_lvl),
      .host_pull(host_pull), .card_pull(card_pull)
   );

   // reference model: 0 hold,1 idle,2/3/4 host wait/drive/release,5/6/7 card
   int m_st [N];
   int m_cnt[N];

   function automatic int next_st(input int st, input int cnt, input bit rx,
                                  input bit h, input bit c);
      if (!rx) return 0;
      case (st)
         0: return 1;
         1: return (!h) ? 2 : ((!c) ? 5 : 1);
         2: return h ? 1 : ((cnt == F-1) ? 3 : 2);
         3: return h ? 4 : 3;
         4: return (cnt == R-1) ? 1 : 4;
         5: return c ? 1 : ((cnt == F-1) ? 6 : 5);
         6: return c ? 7 : 6;
         7: return (cnt == R-1) ? 1 : 7;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_card(input int st);
      return (st == 0) || (st == 3) || (st == 4);
   endfunction

   function automatic bit exp_host(input int st);
      return (st == 6) || (st == 7);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
      end else begin
         for (int i = 0; i < N; i++) begin
            int ns;
            ns = next_st(m_st[i], m_cnt[i], rx_en, host_lvl[i], card_lvl[i]);
            m_cnt[i] = (ns == m_st[i]) ? m_cnt[i] + 1 : 0;
            m_st[i] = ns;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [N-1:0] eh, input logic [N-1:0] ec);
      checks++;
      if (host_pull !== eh || card_pull !== ec) begin
         fails++;
         $display("FAIL %s: host_pull=%b card_pull=%b expected host_pull=%b card_pull=%b",
                  tag, host_pull, card_pull, eh, ec);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED));
      step(2);
      chk("R1 reset", 3'b000, 3'b111);
      rst_n = 1'b1;
      host_ext = 3'b101; card_ext = 3'b010;
      step(3);
      chk("R2 lines ignored while disabled", 3'b000, 3'b111);
      host_ext = '0; card_ext = '0;
      rx_en = 1'b1;
      step(1);
      chk("R3 neutral after enable", 3'b000, 3'b000);

      // R4 host-to-card on lane 0
      host_ext[0] = 1'b1;
      step(F);
      chk("R4 before fall delay", 3'b000, 3'b000);
      step(1);
      chk("R4 copy after fall delay", 3'b000, 3'b001);
      card_ext[0] = 1'b1;
      step(2);
      chk("R8 output side ignored while driving", 3'b000, 3'b001);
      card_ext[0] = 1'b0;
      // R7 release
      host_ext[0] = 1'b0;
      step(R);
      chk("R7 held during release", 3'b000, 3'b001);
      step(1);
      chk("R7 released", 3'b000, 3'b000);

      // R5 card-to-host on lane 1, R10 independence
      card_ext[1] = 1'b1;
      step(F);
      chk("R5 before fall delay", 3'b000, 3'b000);
      step(1);
      chk("R5 copy after fall delay / R10 others idle", 3'b010, 3'b000);
      card_ext[1] = 1'b0;
      step(R + 1);
      chk("R7 card-side release", 3'b000, 3'b000);

      // R6 tie on lane 2
      host_ext[2] = 1'b1; card_ext[2] = 1'b1;
      step(F + 1);
      chk("R6 tie goes to host", 3'b000, 3'b100);
      host_ext[2] = 1'b0; card_ext[2] = 1'b0;
      step(R + 1);
      chk("R6 tie release", 3'b000, 3'b000);

      // R9 short pulse filtered
      host_ext[0] = 1'b1;
      step(3);
      host_ext[0] = 1'b0;
      step(F + 2);
      chk("R9 short pulse never copied", 3'b000, 3'b000);

      // R8 output side pulled during the wait
      host_ext[0] = 1'b1;
      step(2);
      card_ext[0] = 1'b1;
      step(2);
      card_ext[0] = 1'b0;
      step(F - 3);
      chk("R8 output side ignored during wait", 3'b000, 3'b001);
      host_ext[0] = 1'b0;
      step(R + 1);

      // R2 abort mid transfer
      card_ext[1] = 1'b1;
      step(F + 1);
      chk("R5 lane 1 driving before abort", 3'b010, 3'b000);
      rx_en = 1'b0;
      step(1);
      chk("R2 forced hold from any direction", 3'b000, 3'b111);
      card_ext[1] = 1'b0;
      rx_en = 1'b1;
      step(1);
      chk("R3 neutral after re-enable", 3'b000, 3'b000);

      // R11 re-arbitration with far side still low
      host_ext[0] = 1'b1;
      step(F + 1);
      card_ext[0] = 1'b1;
      host_ext[0] = 1'b0;
      step(R + 1);
      chk("R11 released before re-arbitration", 3'b000, 3'b000);
      step(F + 1);
      chk("R11 far side becomes input", 3'b001, 3'b000);
      card_ext[0] = 1'b0;
      step(R + 1);
      chk("R11 released again", 3'b000, 3'b000);

      // random phase against the reference model (R10, R8, R2)
      cmp_on = 1'b1;
      for (int k = 0; k < 6000; k++) begin
         logic [N-1:0] eh, ec;
         @(negedge clk);
         for (int i = 0; i < N; i++) begin
            eh[i] = exp_host(m_st[i]);
            ec[i] = exp_card(m_st[i]);
         end
         chk("R10 random vs model", eh, ec);
         for (int i = 0; i < N; i++) begin
            if (($urandom % 12) == 0) host_ext[i] = ~host_ext[i];
            if (($urandom % 12) == 0) card_ext[i] = ~card_ext[i];
         end
         if (rx_en && (($urandom % 300) == 0)) rx_en = 1'b0;
         else if (!rx_en && (($urandom % 4) == 0)) rx_en = 1'b1;
      end
      finish_run();
   end

endmodule